// File: doc/BRIEF.md
# Configurable Slave-Port Bus Arbiter

This block decides which of several bus masters drives one slave port of a symmetric crossbar. Each master raises a request line. The block answers with a registered one-hot grant vector, and that vector steers the master's path to the slave. An all-zero vector means that no master owns the port.

A single mode input picks the policy, and the mode can differ from one slave port to the next. In fixed mode, every master is given a programmable 4-bit level, packed into one word with master i in bits [4i+3:4i]. The requester with the numerically smallest level wins, and nothing protects a lower-priority master from starving. In round-robin mode, a pointer starts at master 0 after reset. The search for a winner begins at the pointer, and after master k receives a grant the pointer moves to k+1, wrapping back to 0 after the last master.

Once a grant is issued, it stays in place for the whole transfer. A transfer is either a single data beat or a 16-byte burst of four 32-bit beats. The winner of the next arbitration shows on the grant one cycle after the beat that ends the transfer. The mode and level inputs come from register logic elsewhere in the chip. The block runs on the masters' clock, with no clock ratio between them.

Top module: `slave_arbiter`

## Requirements
- R1: While rst_ni is low, gnt_o is all zeros, and the round-robin pointer returns to master 0.
- R2: If no grant is held and req_i is all zeros, gnt_o stays all zeros.
- R3: In fixed mode (mode_rr_i = 0), a new grant goes to the requester whose 4-bit level in prio_i bits [4i+3:4i] has the smallest value. When levels tie, the lower master index wins.
- R4: In fixed mode, a higher-priority master that keeps requesting wins every arbitration, and lower-priority requesters never get the port.
- R5: In round-robin mode (mode_rr_i = 1), the first grant after reset goes to the lowest-numbered requesting master.
- R6: Every grant to master k sets the round-robin search start to k+1, which wraps from the last master to master 0.
- R7: After a grant is issued, gnt_o does not change until the transfer ends, even when req_i changes.
- R8: A beat with burst_i = 0 as the first beat of a transfer ends that transfer. On the next cycle gnt_o shows the new winner, or all zeros if no master requests.
- R9: When burst_i = 1 on the first beat, the transfer lasts four beats. beat_i cycles that fall between beats do not count, and the grant releases only after the fourth beat.
- R10: mode_rr_i matters only at arbitration cycles. A change in mode during a transfer leaves the current grant unchanged.
- R11: gnt_o never has more than one bit set.
- R12: beat_i has no effect while no grant is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, shared with the masters |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_rr_i | input | 1 | 0 selects fixed priority, 1 selects round-robin |
| prio_i | input | N_MST*4 | Packed level per master; a lower value means higher priority |
| req_i | input | N_MST | Request lines, one per master |
| beat_i | input | 1 | A data beat of the granted transfer completes this cycle |
| burst_i | input | 1 | Qualifies the first beat: 1 means a four-beat burst |
| gnt_o | output | N_MST | Registered one-hot grant |

## Verification
A corrupted round-robin pointer does not show at once. It appears at the next arbitration with two or more requesters, as a grant to the wrong master. The bench therefore follows each grant with contended requests that force a wrap. A fault in the beat counter makes the grant release one or more beats early or late during a burst, so every beat of a burst is compared cycle by cycle. A faulty hold condition lets the grant move in the very cycle after a competing request appears, and that cycle is checked directly.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_ROUND = 1'b1
  } arb_mode_e;

  localparam int unsigned LVL_W       = 4;
  localparam int unsigned BUS_BYTES   = 4;
  localparam int unsigned BURST_BYTES = 16;
endpackage

// File: rtl/fixed_pick.sv
module fixed_pick #(
  parameter int unsigned N_MST = 8,
  parameter int unsigned LVL_W = 4
) (
  input  logic [N_MST-1:0]       req_i,
  input  logic [N_MST*LVL_W-1:0] prio_i,
  output logic [N_MST-1:0]       win_o
);
  logic [LVL_W-1:0] lvl [N_MST];

  for (genvar g = 0; g < N_MST; g++) begin : g_lvl
    assign lvl[g] = prio_i[g*LVL_W +: LVL_W];
  end

  always_comb begin
    logic [LVL_W-1:0] best;
    logic             found;
    win_o = '0;
    best  = '1;
    found = 1'b0;
    for (int i = 0; i < N_MST; i++) begin
      // strict compare: ties keep the lower index
      if (req_i[i] && (!found || lvl[i] < best)) begin
        best  = lvl[i];
        found = 1'b1;
        win_o = '0;
        win_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N_MST = 8,
  localparam int unsigned IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [N_MST-1:0] win_o
);
  always_comb begin
    logic found;
    win_o = '0;
    found = 1'b0;
    for (int i = 0; i < N_MST; i++) begin
      int j;
      j = int'(ptr_i) + i;
      if (j >= int'(N_MST)) j = j - int'(N_MST);
      if (!found && req_i[j]) begin
        found    = 1'b1;
        win_o[j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker #(
  parameter int unsigned BEATS = 4,
  localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic beat_i,
  input  logic burst_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             burst_q;
  logic             first;
  logic             eff_burst;
  logic             beat_ok;

  assign first     = (cnt_q == '0);
  assign eff_burst = first ? burst_i : burst_q;
  assign beat_ok   = beat_i & busy_i;
  assign done_o    = beat_ok & (!eff_burst || cnt_q == CNT_W'(BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      burst_q <= 1'b0;
    end else if (beat_ok) begin
      if (first) burst_q <= burst_i;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/slave_arbiter.sv
module slave_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned N_MST = 8,
  localparam int unsigned IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int unsigned BEATS = BURST_BYTES / BUS_BYTES
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_rr_i,
  input  logic [N_MST*LVL_W-1:0] prio_i,
  input  logic [N_MST-1:0]       req_i,
  input  logic                   beat_i,
  input  logic                   burst_i,
  output logic [N_MST-1:0]       gnt_o
);
  logic [N_MST-1:0] gnt_q;
  logic [N_MST-1:0] win_fx;
  logic [N_MST-1:0] win_rr;
  logic [N_MST-1:0] win;
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] win_idx;
  logic             xfer_done;
  logic             arb_open;
  arb_mode_e        mode;

  assign mode = arb_mode_e'(mode_rr_i);

  fixed_pick #(.N_MST(N_MST), .LVL_W(LVL_W)) i_fixed (
    .req_i  (req_i),
    .prio_i (prio_i),
    .win_o  (win_fx)
  );

  rr_pick #(.N_MST(N_MST)) i_rr (
    .req_i (req_i),
    .ptr_i (ptr_q),
    .win_o (win_rr)
  );

  xfer_tracker #(.BEATS(BEATS)) i_xfer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (|gnt_q),
    .beat_i  (beat_i),
    .burst_i (burst_i),
    .done_o  (xfer_done)
  );

  assign win      = (mode == ARB_ROUND) ? win_rr : win_fx;
  assign arb_open = (gnt_q == '0) | xfer_done;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N_MST; i++) begin
      if (win[i]) win_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= '0;
      ptr_q <= '0;
    end else if (arb_open) begin
      gnt_q <= win;
      if (|win) ptr_q <= (win_idx == IDX_W'(N_MST - 1)) ? '0 : win_idx + 1'b1;
    end
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned N_MST = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] req_i,
  input logic [N_MST-1:0] gnt_o,
  input logic             xfer_done_i
);
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R11

  AST_GNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) && !xfer_done_i |=> $stable(gnt_o)); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0) && (req_i == '0) |=> (gnt_o == '0)); // R2

  AST_GNT_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o == '0) || xfer_done_i) && (req_i != '0) |=> ((gnt_o & $past(req_i)) != '0)); // R3

  AST_RELEASE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i && (req_i == '0) |=> (gnt_o == '0)); // R8
endmodule

bind slave_arbiter arb_checker #(.N_MST(N_MST)) i_arb_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .gnt_o       (gnt_o),
  .xfer_done_i (xfer_done)
);

// File: tb/test_slave_arbiter.sv
module test_slave_arbiter;
  localparam int N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mode_rr_i = 1'b0;
  logic [N*4-1:0] prio_i = 32'h0123_4567; // master i level = 7-i
  logic [N-1:0] req_i = '0;
  logic         beat_i = 1'b0;
  logic         burst_i = 1'b0;
  logic [N-1:0] gnt_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [N-1:0] exp_q [$];
  string        tag_q [$];

  always #10 clk_i = ~clk_i;

  slave_arbiter #(.N_MST(N)) i_slave_arbiter (
    .clk_i, .rst_ni, .mode_rr_i, .prio_i, .req_i, .beat_i, .burst_i, .gnt_o
  );

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt_o=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus plus expected grant after the next edge
  task automatic step(input logic [N-1:0] req, input logic beat, input logic burst,
                      input logic mode, input logic [N-1:0] exp, input string tag);
    @(negedge clk_i);
    req_i = req; beat_i = beat; burst_i = burst; mode_rr_i = mode;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [N-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(gnt_o, e, t);
      n_cmp++; // R11
      if (!$onehot0(gnt_o)) begin
        n_bad++;
        $display("FAIL R11: gnt_o=%b expected at most one bit set", gnt_o);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = '0; beat_i = 1'b0; burst_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check(gnt_o, '0, "R1 reset");
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // fixed mode
    step(8'h00, 0, 0, 0, 8'h00, "R2 idle no request");
    step(8'h05, 0, 0, 0, 8'h04, "R3 lower level wins");
    step(8'h84, 0, 0, 0, 8'h04, "R7 held against higher requester");
    step(8'h84, 1, 0, 0, 8'h80, "R8 single beat ends transfer");
    step(8'h81, 1, 0, 0, 8'h80, "R4 higher master keeps port");
    step(8'h81, 1, 0, 0, 8'h80, "R4 lower master starved");
    step(8'h01, 1, 0, 0, 8'h01, "R3 sole requester");
    step(8'h80, 1, 1, 0, 8'h01, "R9 burst beat 1");
    step(8'h80, 1, 0, 0, 8'h01, "R9 burst beat 2");
    step(8'h80, 0, 0, 0, 8'h01, "R9 gap cycle");
    step(8'h80, 1, 0, 0, 8'h01, "R9 burst beat 3");
    step(8'h80, 1, 0, 0, 8'h80, "R9 burst beat 4 releases");
    step(8'h00, 1, 0, 0, 8'h00, "R8 release to empty");
    step(8'h00, 1, 0, 0, 8'h00, "R12 beat while idle");
    step(8'h02, 1, 0, 0, 8'h02, "R12 fresh grant");
    step(8'h02, 1, 0, 0, 8'h02, "R12 single beat still ends transfer");
    step(8'h00, 1, 0, 0, 8'h00, "R8 release");
    // round-robin: last grant was master 1, search starts at 2
    step(8'h11, 0, 0, 1, 8'h10, "R6 search from pointer");
    step(8'h11, 0, 0, 0, 8'h10, "R10 mode change mid transfer");
    step(8'h11, 1, 0, 1, 8'h01, "R6 wrap to master 0");
    step(8'h11, 1, 0, 1, 8'h10, "R6 rotate to master 4");
    step(8'h11, 1, 0, 1, 8'h01, "R6 rotate back");
    step(8'h11, 1, 0, 0, 8'h10, "R10 mode applied at arbitration");
    step(8'h00, 1, 0, 0, 8'h00, "R8 release");
    @(negedge clk_i);
    do_reset();
    step(8'h0C, 0, 0, 1, 8'h04, "R5 port order after reset");
    step(8'h0C, 1, 0, 1, 8'h08, "R6 next after master 2");
    step(8'h0C, 1, 0, 1, 8'h04, "R6 wrap past last master");
    @(negedge clk_i);
    prio_i = '0;
    step(8'h0C, 1, 0, 0, 8'h04, "R3 tie lower index");
    step(8'h00, 1, 0, 0, 8'h00, "R8 release");
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule